// File: doc/BRIEF.md
# Signed Restoring Divider

This block takes two N-bit two's-complement operands, a dividend and a divisor, and returns an N-bit quotient and an N-bit remainder. Each operand is first reduced to its unsigned magnitude. The magnitudes then go through long division that yields one quotient bit per clock. Each step shifts the next dividend bit into a partial remainder. It then tests the divisor against that partial remainder by adding the divisor's two's complement. The subtraction is kept only when the divisor fits.

When the last bit has been produced, a sign stage corrects both results so that dividend = quotient × divisor + remainder. The quotient truncates toward zero, and the remainder carries the sign of the dividend.

A single-cycle `start` launches an operation while the block is idle. `busy` covers the iteration. `done` pulses once when the results are valid, and the results then hold until the next accepted start. A zero divisor skips the iteration and reports at once through `div_by_zero`.

Top module: `signed_restoring_divider`

## Requirements
- R1: After reset, `busy`, `done` and `div_by_zero` are low, and `quotient` and `remainder` are zero.
- R2: `start` is accepted only on an edge where `busy` is low. A nonzero-divisor operation raises `busy` from the next cycle. A `start` seen while `busy` is high is ignored, and the running operation completes with its original operands and no extra `done`.
- R3: With a nonzero divisor, `done` is high for exactly one cycle. It rises on the (N+1)-th clock edge, counting the edge that samples `start` as the first, and `busy` falls on that same edge.
- R4: The magnitude of `quotient` equals floor(|dividend| / |divisor|), which is truncation toward zero.
- R5: `remainder` is zero or has the sign of the dividend, and its magnitude is smaller than |divisor|.
- R6: A nonzero quotient is negative exactly when the dividend and divisor signs differ. For example, 17 / -3 gives -5 remainder 2, and -17 / -3 gives 5 remainder -2.
- R7: `quotient` × `divisor` + `remainder` equals `dividend`, taken modulo 2^N.
- R8: The most negative value divided by -1 wraps to the most negative value as quotient, with remainder zero.
- R9: A zero divisor sets `div_by_zero`, gives an all-ones `quotient` and a `remainder` equal to the dividend, and raises `done` on the edge that samples `start`. `busy` stays low.
- R10: The results and `div_by_zero` hold after `done` until the next accepted `start`. An accepted start with a nonzero divisor clears `div_by_zero`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; sampled while idle |
| dividend | input | N | Two's-complement dividend, sampled with start |
| divisor | input | N | Two's-complement divisor, sampled with start |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle pulse: results valid |
| quotient | output | N | Two's-complement quotient |
| remainder | output | N | Two's-complement remainder |
| div_by_zero | output | 1 | Last accepted operation had a zero divisor |

## Verification
The hardest case to reach from the ports is the overflow and asymmetry region around the most negative value. There the magnitude needs all N bits, and the sign fix-up has to wrap rather than saturate. Random operands almost never land there. The stimulus therefore lists those operand pairs directly, next to the four sign combinations of 17 and 3. It also fires a second `start` in the middle of a running division, and issues a zero-divisor request straight after a completion. Each result is predicted with integer division at wider precision, truncated to N bits.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } div_phase_e;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int N = 16
) (
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic [N-1:0] dvd_mag,
  output logic [N-1:0] dvs_mag,
  output logic         dvd_neg,
  output logic         dvs_neg,
  output logic         dvs_zero
);
  localparam logic [N-1:0] ONE = N'(1);

  function automatic logic [N-1:0] magnitude(input logic [N-1:0] v);
    return v[N-1] ? (~v + ONE) : v;
  endfunction

  assign dvd_neg  = dividend[N-1];
  assign dvs_neg  = divisor[N-1];
  assign dvd_mag  = magnitude(dividend);
  assign dvs_mag  = magnitude(divisor);
  assign dvs_zero = (divisor == '0);
endmodule

// File: rtl/div_restore_step.sv
module div_restore_step #(
  parameter int N = 16
) (
  input  logic [N-1:0] part_rem,
  input  logic         next_bit,
  input  logic [N-1:0] dvs,
  output logic         take,
  output logic [N-1:0] new_rem
);
  localparam int SW = N + 2;

  // Trial subtraction by complement addition; carry out set means no borrow.
  function automatic logic [SW-1:0] trial_sub(input logic [N:0] a, input logic [N:0] b);
    return {1'b0, a} + {1'b0, ~b} + SW'(1);
  endfunction

  logic [N:0]    partial;
  logic [SW-1:0] diff;

  assign partial = {part_rem, next_bit};
  assign diff    = trial_sub(partial, {1'b0, dvs});
  assign take    = diff[SW-1];
  assign new_rem = take ? diff[N-1:0] : partial[N-1:0];
endmodule

// File: rtl/div_sign_fixup.sv
module div_sign_fixup #(
  parameter int N = 16
) (
  input  logic [N-1:0] q_mag,
  input  logic [N-1:0] r_mag,
  input  logic         dvd_neg,
  input  logic         dvs_neg,
  output logic [N-1:0] q_out,
  output logic [N-1:0] r_out
);
  localparam logic [N-1:0] ONE = N'(1);

  function automatic logic [N-1:0] signed_from(input logic [N-1:0] m, input logic neg);
    return neg ? (~m + ONE) : m;
  endfunction

  assign q_out = signed_from(q_mag, dvd_neg ^ dvs_neg);
  assign r_out = signed_from(r_mag, dvd_neg);
endmodule

// File: rtl/signed_restoring_divider.sv
module signed_restoring_divider #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder,
  output logic         div_by_zero
);
  import div_pkg::*;

  localparam int CW = $clog2(N + 1);

  div_phase_e    phase;
  logic [CW-1:0] steps_left;
  logic [N-1:0]  acc;
  logic [N-1:0]  qsh;
  logic [N-1:0]  dvs_r;
  logic          dvd_neg_r;
  logic          dvs_neg_r;

  logic [N-1:0]  dvd_mag;
  logic [N-1:0]  dvs_mag;
  logic          dvd_neg;
  logic          dvs_neg;
  logic          dvs_zero;
  logic          step_take;
  logic [N-1:0]  step_rem;
  logic [N-1:0]  qsh_next;
  logic [N-1:0]  fix_q;
  logic [N-1:0]  fix_r;

  // Named events for the checker
  logic          accept;
  logic          last_step;

  assign busy      = (phase == PH_RUN);
  assign accept    = start && !busy;
  assign last_step = busy && (steps_left == CW'(1));
  assign qsh_next  = {qsh[N-2:0], step_take};

  div_operand_prep #(.N(N)) u_prep (
    .dividend (dividend),
    .divisor  (divisor),
    .dvd_mag  (dvd_mag),
    .dvs_mag  (dvs_mag),
    .dvd_neg  (dvd_neg),
    .dvs_neg  (dvs_neg),
    .dvs_zero (dvs_zero)
  );

  div_restore_step #(.N(N)) u_step (
    .part_rem (acc),
    .next_bit (qsh[N-1]),
    .dvs      (dvs_r),
    .take     (step_take),
    .new_rem  (step_rem)
  );

  div_sign_fixup #(.N(N)) u_fix (
    .q_mag    (qsh_next),
    .r_mag    (step_rem),
    .dvd_neg  (dvd_neg_r),
    .dvs_neg  (dvs_neg_r),
    .q_out    (fix_q),
    .r_out    (fix_r)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      steps_left  <= '0;
      acc         <= '0;
      qsh         <= '0;
      dvs_r       <= '0;
      dvd_neg_r   <= 1'b0;
      dvs_neg_r   <= 1'b0;
      done        <= 1'b0;
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (dvs_zero) begin
          div_by_zero <= 1'b1;
          quotient    <= '1;
          remainder   <= dividend;
          done        <= 1'b1;
        end else begin
          div_by_zero <= 1'b0;
          phase       <= PH_RUN;
          steps_left  <= CW'(N);
          acc         <= '0;
          qsh         <= dvd_mag;
          dvs_r       <= dvs_mag;
          dvd_neg_r   <= dvd_neg;
          dvs_neg_r   <= dvs_neg;
        end
      end else if (busy) begin
        acc        <= step_rem;
        qsh        <= qsh_next;
        steps_left <= steps_left - CW'(1);
        if (last_step) begin
          phase     <= PH_IDLE;
          done      <= 1'b1;
          quotient  <= fix_q;
          remainder <= fix_r;
        end
      end
    end
  end
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         accept,
  input logic [N-1:0] dividend,
  input logic [N-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] quotient,
  input logic [N-1:0] remainder,
  input logic         div_by_zero
);
  int unsigned  since_accept;
  logic         cap_zero;
  logic         cap_sign;
  logic [N-1:0] cap_dividend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_accept <= 0;
      cap_zero     <= 1'b0;
      cap_sign     <= 1'b0;
      cap_dividend <= '0;
    end else if (accept) begin
      since_accept <= 1;
      cap_zero     <= (divisor == '0);
      cap_sign     <= dividend[N-1];
      cap_dividend <= dividend;
    end else if (since_accept != 0 && since_accept < N + 2) begin
      since_accept <= since_accept + 1;
    end
  end

  assert_busy_done_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_done_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);

  assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> since_accept == (cap_zero ? 1 : N + 1));

  assert_accept_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (divisor != '0) |=> busy);

  assert_zero_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && div_by_zero |-> (quotient == '1) && (remainder == cap_dividend) && cap_zero);

  assert_rem_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !div_by_zero && (remainder != '0) |-> remainder[N-1] == cap_sign);

  assert_hold_results_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !done && !start |=> $stable(quotient) && $stable(remainder));
endmodule

bind signed_restoring_divider div_checker #(.N(N)) u_div_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .accept      (accept),
  .dividend    (dividend),
  .divisor     (divisor),
  .busy        (busy),
  .done        (done),
  .quotient    (quotient),
  .remainder   (remainder),
  .div_by_zero (div_by_zero)
);

// File: tb/signed_restoring_divider_test.sv
module signed_restoring_divider_test;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] q;
    logic [W-1:0] r;
    logic         dz;
    int           t0;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;
  logic         div_by_zero;

  int   vectors = 0;
  int   miscompares = 0;
  int   cyc = 0;
  bit   finished = 1'b0;
  exp_t scb[$];
  logic [W-1:0] last_q = '0;
  logic [W-1:0] last_r = '0;
  logic         last_dz = 1'b0;

  signed_restoring_divider #(.N(W)) uut (
    .clk, .rst_n, .start, .dividend, .divisor,
    .busy, .done, .quotient, .remainder, .div_by_zero
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic longint sx(input logic [W-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint absl(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  // Driver: wait for idle, pulse start, push prediction
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    longint ai, bi;
    while (busy) @(negedge clk);
    ai = sx(a);
    bi = sx(b);
    e.a = a;
    e.b = b;
    if (bi == 0) begin
      e.q = '1;
      e.r = a;
      e.dz = 1'b1;
    end else begin
      e.q = W'(ai / bi);
      e.r = W'(ai % bi);
      e.dz = 1'b0;
    end
    e.t0 = cyc;
    scb.push_back(e);
    dividend = a;
    divisor  = b;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (bi != 0) check(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
    else         check(busy == 1'b0, "R9 busy stays low", longint'(busy), 0);
  endtask

  // Monitor: pop and compare on every done
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (scb.size() == 0) begin
        check(1'b0, "R2 unexpected done", 1, 0);
      end else begin
        exp_t e;
        longint qa, ra, ba;
        e = scb.pop_front();
        qa = sx(quotient);
        ra = sx(remainder);
        ba = sx(e.b);
        if (e.dz) begin
          check(cyc - e.t0 == 1, "R9 latency", cyc - e.t0, 1);
          check(div_by_zero == 1'b1, "R9 flag", longint'(div_by_zero), 1);
          check(quotient == e.q, "R9 quotient", longint'(quotient), longint'(e.q));
          check(remainder == e.r, "R9 remainder", longint'(remainder), longint'(e.r));
        end else begin
          check(cyc - e.t0 == W + 1, "R3 latency", cyc - e.t0, W + 1);
          check(div_by_zero == 1'b0, "R10 flag cleared", longint'(div_by_zero), 0);
          check(quotient == e.q, "R4 R6 R8 quotient", qa, sx(e.q));
          check(remainder == e.r, "R5 remainder", ra, sx(e.r));
          check(W'(qa * ba + ra) == e.a, "R7 identity", longint'(W'(qa * ba + ra)), longint'(e.a));
          check(absl(ra) < absl(ba), "R5 remainder magnitude", absl(ra), absl(ba));
        end
        last_q  = quotient;
        last_r  = remainder;
        last_dz = div_by_zero;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0 && done == 1'b0 && div_by_zero == 1'b0, "R1 flags", longint'({busy, done, div_by_zero}), 0);
    check(quotient == '0 && remainder == '0, "R1 results", longint'(quotient) + longint'(remainder), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 / R5 sign combinations
    issue(W'(17), W'(3));
    issue(W'(17), W'(-3));
    issue(W'(-17), W'(3));
    issue(W'(-17), W'(-3));
    // R8 and most-negative corners
    issue(W'(-32768), W'(-1));
    issue(W'(-32768), W'(1));
    issue(W'(-32768), W'(-32768));
    issue(W'(32767), W'(-32768));
    issue(W'(-32767), W'(-32768));
    issue(W'(3), W'(7));
    issue(W'(-3), W'(7));
    issue(W'(0), W'(5));
    issue(W'(1), W'(1));

    // R9 zero divisor, then R10 flag clear on next op
    issue(W'(-1), W'(0));
    issue(W'(123), W'(0));
    issue(W'(100), W'(50));

    // R2: start during busy is ignored
    while (busy) @(negedge clk);
    issue(W'(1000), W'(-7));
    repeat (3) @(negedge clk);
    dividend = W'(5);
    divisor  = W'(0);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy kept on ignored start", longint'(busy), 1);

    // R10: results hold after done
    while (busy || scb.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    check(done == 1'b0, "R10 done low while idle", longint'(done), 0);
    check(quotient == last_q && remainder == last_r && div_by_zero == last_dz,
          "R10 results held", longint'(quotient), longint'(last_q));

    // Random operands with occasional zero and small divisors
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      ra = W'($urandom);
      rb = W'($urandom);
      if (i % 25 == 0) rb = '0;
      else if (i % 7 == 0) rb = W'($signed($urandom_range(0, 8)) - 4);
      if (i % 11 == 0) ra = {1'b1, {(W-1){1'b0}}};
      issue(ra, rb);
    end

    while (busy || scb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(scb.size() == 0, "R2 all results delivered", scb.size(), 0);
    finish_run();
  end
endmodule